// File: doc/BRIEF.md
# Key-protected watchdog reset timer

This block is a watchdog timer on a small word-addressed register bus. The reference clock is divided by a programmable prescaler, and each divided tick decrements a 16-bit down-counter. While the timer runs and software does not restart it in time, the counter runs out and the block raises a one-cycle pulse on its reset output. The counter then reloads and the timer keeps running.

Software cannot change any control value with a single write. Each of the four data registers (restart, reload value, run control, prescale) has a lock register next to it. The lock opens only when software writes the right keys in the right order. Each lock register reports its unlock progress in its two lowest bits. An open lock accepts exactly one write to its data register and then closes again. The run-control lock needs three keys; each of the other locks needs two.

Top module: `kwdt_top`

## Requirements
- R1: After reset, wdt_rst is low, the timer is stopped, the reload value reads 0xFFFF, the prescale reads 0, and every lock status reads 00.
- R2: The word index addr selects one of eight registers: 0 restart-lock, 1 restart, 2 reload-lock, 3 reload, 4 run-lock, 5 run, 6 prescale-lock, 7 prescale. The rdata output is updated at the clock edge that samples rd_en. Each lock register returns its status in bits 1:0 and zero in bits 31:2. The restart register reads 0. The reload value is returned in bits 15:0, the prescale in bits 15:0 and the run state in bit 0.
- R3: Each two-key lock compares the full 32-bit write data against its keys, in order. The restart lock takes 0x5555 then 0xAAAA. The reload lock takes 0x6666 then 0xBBBB. The prescale lock takes 0x5A5A then 0xA5A5. The status reads 01 after the first key and 11 after the second.
- R4: The run lock takes 0x7777, then 0xCCCC, then 0xDDDD. Its status reads 01, then 10, then 11, and it can never move straight from 00 to 10 or 11.
- R5: A lock write that is not the next expected key sets that lock's status to 00. This covers a key given out of order and any key written while the lock is already open.
- R6: A write to a data register whose lock status is not 11 changes nothing. The lock status is also left as it was.
- R7: A write to a data register whose lock is open is accepted, and the lock status returns to 00. A second write without a new unlock is ignored.
- R8: An accepted write to the run register with bit 0 = 1 starts the timer, and with bit 0 = 0 stops it. No pulse appears on wdt_rst while the timer is stopped.
- R9: Let D be the prescale value plus 1, and C the reload value (0 acts as 1). The first pulse on wdt_rst is high in the cycle after the C·D-th clock edge following the edge that accepted the starting write. Further pulses follow every C·D edges, and each pulse lasts one cycle.
- R10: An accepted restart write with bit 0 = 1 restarts the count. The next pulse then comes C·D edges after that write's edge, and no pulse follows it directly.
- R11: A new reload value written while the timer runs does not shorten the period in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| rd_en | input | 1 | Register read strobe, sampled at the rising edge |
| addr | input | 3 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Register accesses complete at the edge that samples the strobe. Lock status and data read back one read cycle later. The bench therefore drives each access at a falling edge and reads rdata at the next falling edge. For the timer, the bench counts falling edges from the edge that accepted the starting, restart or reload write, and expects wdt_rst high exactly at counts C·D, 2·C·D and so on, and low at every other count. The restart and reload cases keep counting across their unlock writes, so a late or missing effect of the write shows up as a pulse at the wrong count.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int N_LOCKS  = 4;
  localparam int LK_KICK  = 0;
  localparam int LK_CHG   = 1;
  localparam int LK_RUN   = 2;
  localparam int LK_PRE   = 3;
  localparam int KEY_W    = 16;
  localparam int MAX_KEYS = 3;

  // keys per lock, key 0 in the lowest slice
  localparam logic [N_LOCKS-1:0][MAX_KEYS*KEY_W-1:0] LOCK_KEYS = {
    {16'h0000, 16'hA5A5, 16'h5A5A},
    {16'hDDDD, 16'hCCCC, 16'h7777},
    {16'h0000, 16'hBBBB, 16'h6666},
    {16'h0000, 16'hAAAA, 16'h5555}
  };

  function automatic int key_count(input int g);
    return (g == LK_RUN) ? 3 : 2;
  endfunction
endpackage

// File: rtl/kwdt_rst_sync.sv
module kwdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/kwdt_keylock.sv
module kwdt_keylock #(
  parameter int          NKEYS = 2,
  parameter int          KEY_W = 16,
  parameter logic [47:0] KEYS  = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_wr,
  input  logic        data_wr,
  input  logic [31:0] wdata,
  output logic [1:0]  status,
  output logic        open
);
  localparam int STG_W = 2;

  logic [STG_W-1:0] stage_q, stage_d;
  logic [KEY_W-1:0] exp_key;
  logic             key_hit;

  always_comb begin
    exp_key = '0;
    for (int i = 0; i < NKEYS; i++) begin
      if (stage_q == STG_W'(i)) exp_key = KEYS[KEY_W*i +: KEY_W];
    end
  end

  assign open    = (stage_q == STG_W'(NKEYS));
  assign key_hit = !open && (wdata == 32'(exp_key));
  assign status  = open ? 2'b11 : stage_q;

  always_comb begin
    stage_d = stage_q;
    if (lk_wr) begin
      stage_d = key_hit ? stage_q + 1'b1 : '0;
    end else if (data_wr && open) begin
      stage_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  input  logic [PRE_W-1:0] prescale,
  output logic             fire
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire_q, fire_d;
  logic             tick;

  assign tick = (pcnt_q >= prescale);

  always_comb begin
    pcnt_d = pcnt_q;
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (!run || restart) begin
      pcnt_d = '0;
      cnt_d  = reload;
    end else if (tick) begin
      pcnt_d = '0;
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d  = reload;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '1;
      fire_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wdt_rst
);
  logic                    rst_sn;
  logic [N_LOCKS-1:0]      lk_wr, dt_wr, lk_open, acc;
  logic [N_LOCKS-1:0][1:0] lk_stat;
  logic [CNT_W-1:0]        chg_q, chg_d;
  logic [PRE_W-1:0]        pre_q, pre_d;
  logic                    en_q, en_d;
  logic                    kick;
  logic [31:0]             rd_d, rd_q;

  kwdt_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  for (genvar g = 0; g < N_LOCKS; g++) begin : g_lock
    assign lk_wr[g] = wr_en && (addr == {2'(g), 1'b0});
    assign dt_wr[g] = wr_en && (addr == {2'(g), 1'b1});
    assign acc[g]   = dt_wr[g] && lk_open[g];

    kwdt_keylock #(
      .NKEYS(key_count(g)),
      .KEY_W(KEY_W),
      .KEYS (LOCK_KEYS[g])
    ) u_lock (
      .clk    (clk),
      .rst_n  (rst_sn),
      .lk_wr  (lk_wr[g]),
      .data_wr(dt_wr[g]),
      .wdata  (wdata),
      .status (lk_stat[g]),
      .open   (lk_open[g])
    );
  end

  // control registers
  always_comb begin
    chg_d = chg_q;
    pre_d = pre_q;
    en_d  = en_q;
    if (acc[LK_CHG]) chg_d = wdata[CNT_W-1:0];
    if (acc[LK_PRE]) pre_d = wdata[PRE_W-1:0];
    if (acc[LK_RUN]) en_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      chg_q <= '1;
      pre_q <= '0;
      en_q  <= 1'b0;
    end else begin
      chg_q <= chg_d;
      pre_q <= pre_d;
      en_q  <= en_d;
    end
  end

  assign kick = acc[LK_KICK] && wdata[0];

  kwdt_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_sn),
    .run     (en_q),
    .restart (kick),
    .reload  (chg_q),
    .prescale(pre_q),
    .fire    (wdt_rst)
  );

  // read path
  always_comb begin
    rd_d = '0;
    if (!addr[0]) begin
      rd_d = {30'b0, lk_stat[addr[2:1]]};
    end else begin
      case (addr[2:1])
        2'(LK_CHG): rd_d = 32'(chg_q);
        2'(LK_RUN): rd_d = {31'b0, en_q};
        2'(LK_PRE): rd_d = 32'(pre_q);
        default:    rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:2]      rdata_hi,
  input logic             wdt_rst,
  input logic             en_q,
  input logic [CNT_W-1:0] chg_q,
  input logic [3:0][1:0]  lk_stat,
  input logic [3:0]       lk_open
);
  AST_LOCK_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !addr[0] |=> rdata_hi == '0); // R2

  AST_RUN_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stat[2] == 2'b00 |=> !lk_stat[2][1]); // R4

  AST_WRONG_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd0 && wdata != 32'h5555 && wdata != 32'hAAAA
    |=> lk_stat[0] == 2'b00); // R5

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd3 && !lk_open[1] |=> $stable(chg_q)); // R6

  AST_RELOCK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd3 && lk_open[1] |=> lk_stat[1] == 2'b00); // R7

  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(en_q)); // R8

  AST_KICK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd1 && lk_open[0] && wdata[0] |=> !wdt_rst); // R10
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata_hi(rdata[31:2]),
  .wdt_rst (wdt_rst),
  .en_q    (en_q),
  .chg_q   (chg_q),
  .lk_stat (lk_stat),
  .lk_open (lk_open)
);

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        wdt_rst;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;

  always #4 clk = ~clk;

  kwdt_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v, exp, req);
  endtask

  task automatic unlock(input int g);
    case (g)
      0: begin wr(3'd0, 32'h5555); wr(3'd0, 32'hAAAA); end
      1: begin wr(3'd2, 32'h6666); wr(3'd2, 32'hBBBB); end
      2: begin wr(3'd4, 32'h7777); wr(3'd4, 32'hCCCC); wr(3'd4, 32'hDDDD); end
      default: begin wr(3'd6, 32'h5A5A); wr(3'd6, 32'hA5A5); end
    endcase
  endtask

  task automatic set_reg(input int g, input logic [31:0] d);
    unlock(g);
    wr(3'(2*g+1), d);
  endtask

  // count falling edges n=from..to after an accepting edge; expect pulses at first+k*period
  task automatic watch(input int from, input int to, input int first, input int period, input string req);
    for (int n = from; n <= to; n++) begin
      logic e;
      @(negedge clk);
      e = (first >= 0) && (period > 0) && (n >= first) && ((n - first) % period == 0);
      check({31'b0, wdt_rst}, {31'b0, e}, req);
    end
  endtask

  task automatic t_reset();
    check({31'b0, wdt_rst}, 32'h0, "R1");
    rd_check(3'd0, 32'h0, "R1");
    rd_check(3'd1, 32'h0, "R2");
    rd_check(3'd2, 32'h0, "R1");
    rd_check(3'd3, 32'hFFFF, "R1");
    rd_check(3'd4, 32'h0, "R1");
    rd_check(3'd5, 32'h0, "R1");
    rd_check(3'd6, 32'h0, "R1");
    rd_check(3'd7, 32'h0, "R1");
  endtask

  task automatic t_locks();
    wr(3'd0, 32'h5555);     rd_check(3'd0, 32'h1, "R3");
    wr(3'd0, 32'hAAAA);     rd_check(3'd0, 32'h3, "R3");
    wr(3'd0, 32'h5555);     rd_check(3'd0, 32'h0, "R5");
    wr(3'd6, 32'h5A5A);     rd_check(3'd6, 32'h1, "R3");
    wr(3'd6, 32'h1234);     rd_check(3'd6, 32'h0, "R5");
    wr(3'd6, 32'hFFFF5A5A); rd_check(3'd6, 32'h0, "R3");
    wr(3'd2, 32'hBBBB);     rd_check(3'd2, 32'h0, "R5");
    wr(3'd4, 32'h7777);     rd_check(3'd4, 32'h1, "R4");
    wr(3'd4, 32'hCCCC);     rd_check(3'd4, 32'h2, "R4");
    wr(3'd4, 32'hDDDD);     rd_check(3'd4, 32'h3, "R4");
    wr(3'd5, 32'h0);        rd_check(3'd4, 32'h0, "R7");
    wr(3'd4, 32'hCCCC);     rd_check(3'd4, 32'h0, "R5");
  endtask

  task automatic t_ignore();
    wr(3'd3, 32'h1234);     rd_check(3'd3, 32'hFFFF, "R6");
    wr(3'd2, 32'h6666);
    wr(3'd3, 32'h1234);     rd_check(3'd3, 32'hFFFF, "R6");
    rd_check(3'd2, 32'h1, "R6");
    wr(3'd2, 32'hBBBB);
    wr(3'd3, 32'h0005);     rd_check(3'd3, 32'h5, "R7");
    rd_check(3'd2, 32'h0, "R7");
    wr(3'd3, 32'h0009);     rd_check(3'd3, 32'h5, "R7");
    wr(3'd7, 32'h0004);     rd_check(3'd7, 32'h0, "R6");
    wr(3'd1, 32'h1);        rd_check(3'd1, 32'h0, "R2");
  endtask

  task automatic t_run();
    set_reg(2, 32'h1);
    watch(1, 16, 5, 5, "R9");
    rd_check(3'd5, 32'h1, "R8");
    set_reg(2, 32'h0);
    watch(1, 20, -1, 0, "R8");
    rd_check(3'd5, 32'h0, "R8");
  endtask

  task automatic t_prescale();
    set_reg(3, 32'h2);
    set_reg(1, 32'h4);
    set_reg(2, 32'h1);
    watch(1, 30, 12, 12, "R9");
    set_reg(2, 32'h0);
  endtask

  task automatic t_kick();
    set_reg(3, 32'h0);
    set_reg(1, 32'd10);
    set_reg(2, 32'h1);
    watch(1, 6, -1, 0, "R10");
    unlock(0);
    wr(3'd1, 32'h1);
    watch(1, 22, 10, 10, "R10");
    set_reg(2, 32'h0);
  endtask

  task automatic t_reload();
    set_reg(1, 32'd8);
    set_reg(2, 32'h1);
    watch(1, 3, -1, 0, "R11");
    set_reg(1, 32'd3);
    watch(7, 20, 8, 3, "R11");
    set_reg(2, 32'h0);
  endtask

  task automatic t_zero();
    set_reg(3, 32'h1);
    set_reg(1, 32'h0);
    set_reg(2, 32'h1);
    watch(1, 8, 2, 2, "R9");
    set_reg(2, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check({31'b0, wdt_rst}, 32'h0, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_locks();
    t_ignore();
    t_run();
    t_prescale();
    t_kick();
    t_reload();
    t_zero();
    finish_run();
  end
endmodule